// File: doc/BRIEF.md
# Complex Conjugate Correlation Tile

This block is a square grid of B×B multiply-accumulate cells that correlates two groups of B complex receiver samples. In every time step it takes one input beat carrying the B "y" samples, then one beat carrying the B "x" samples. Cell (i,j) multiplies x lane i by the complex conjugate of y lane j and adds the product to its own accumulator. Each x sample is therefore shared by all B cells of its row, and each y sample by all B cells of its column.

A block begins with a start pulse, which zeroes every accumulator. Integration then runs for a fixed window of WINDOW time steps. After the last x beat of the window, input is closed and the B×B complex sums leave one at a time over a valid/ready stream. When the last sum has been taken, the tile waits for the next start pulse. Samples are signed fixed point, with an 8-bit real part and an 8-bit imaginary part. Accumulators are 32-bit signed.

Top module: `corr_tile`

## Requirements
- R1: While reset is held and right after it, `in_ready_o` and `out_valid_o` are both 0.
- R2: A `start_i` pulse while idle (neither `in_ready_o` nor `out_valid_o` high) zeroes all accumulators, and `in_ready_o` is 1 from the next cycle.
- R3: Accepted beats alternate, y first and then x. On each accepted x beat, cell (i,j) adds re = xr·yr + xi·yi and im = xi·yr − xr·yi. Here x is lane i of the x beat and y is lane j of the preceding y beat. Lane k of `in_data_i` has its real part in bits [16k+15:16k+8] and its imaginary part in bits [16k+7:16k], both two's complement.
- R4: After exactly WINDOW accepted x beats (2·WINDOW beats in all), `in_ready_o` falls and `out_valid_o` rises in the next cycle. `in_ready_o` is 0 whenever the tile is not integrating, and beats offered while it is 0 are ignored.
- R5: Results leave in row-major order: the k-th result is cell (k/B, k mod B). `out_last_o` is 1 only together with the final result.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_re_o`, `out_im_o` and `out_last_o` hold their values into the next cycle.
- R7: After the handshake on the last result, the tile is idle in the next cycle. A `start_i` pulse during integration has no effect on the sums.
- R8: A full window of full-scale samples (all parts −128) gives re = 33554432 and im = 0 in every cell, with no wrap.
- R9: Cycles with `in_valid_i` low change no accumulator and do not advance the y/x order or the window count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a block when idle |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Tile is integrating and takes beats |
| in_data_i | input | B·2·SW | B complex samples, lane k at bits [16k+15:16k] |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| out_re_o | output | ACC_W | Real part of the current sum |
| out_im_o | output | ACC_W | Imaginary part of the current sum |
| out_last_o | output | 1 | Final result of the block |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are: input and output phases never overlap, a start from idle opens the input, the window ends after exactly 2·WINDOW accepted beats, the tile goes idle after the last handshake, and outputs hold steady under backpressure. What the checker cannot show is whether the sums are right. The bench's scenarios show that, by comparing every sum against its own reference. They also show row-major order, clearing between blocks, immunity to stray start pulses and idle gaps, and the full-scale case with no overflow.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DRAIN = 2'd2
  } corr_state_e;
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int WINDOW = 1024,
  parameter int NCELL  = 16,
  localparam int STEP_W = (WINDOW > 1) ? $clog2(WINDOW) : 1,
  localparam int IDX_W  = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             clr_o,
  output logic             y_load_o,
  output logic             mac_en_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  corr_state_e      state_q;
  logic             phase_x_q;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0] idx_q;
  logic             beat, win_end, take, take_last;

  assign in_ready_o  = (state_q == ST_INTEG);
  assign out_valid_o = (state_q == ST_DRAIN);
  assign out_last_o  = out_valid_o && (idx_q == IDX_W'(NCELL - 1));
  assign clr_o       = (state_q == ST_IDLE) && start_i;
  assign beat        = in_valid_i && in_ready_o;
  assign y_load_o    = beat && !phase_x_q;
  assign mac_en_o    = beat && phase_x_q;
  assign win_end     = mac_en_o && (step_q == STEP_W'(WINDOW - 1));
  assign take        = out_valid_o && out_ready_i;
  assign take_last   = take && out_last_o;
  assign rd_idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_x_q <= 1'b0;
      step_q    <= '0;
      idx_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          phase_x_q <= 1'b0;
          step_q    <= '0;
          idx_q     <= '0;
          if (start_i) state_q <= ST_INTEG;
        end
        ST_INTEG: begin
          if (beat) phase_x_q <= ~phase_x_q;
          if (win_end) begin
            step_q  <= '0;
            state_q <= ST_DRAIN;
          end else if (mac_en_o) begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (take_last) begin
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end else if (take) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/corr_cell.sv
module corr_cell #(
  parameter int SW = 8,
  parameter int AW = 32,
  localparam int MW = 2 * SW,
  localparam int PW = 2 * SW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [SW-1:0] x_re_i,
  input  logic signed [SW-1:0] x_im_i,
  input  logic signed [SW-1:0] y_re_i,
  input  logic signed [SW-1:0] y_im_i,
  output logic signed [AW-1:0] acc_re_o,
  output logic signed [AW-1:0] acc_im_o
);
  logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [PW-1:0] p_re, p_im;

  // x * conj(y)
  always_comb begin
    m_rr = MW'(x_re_i) * MW'(y_re_i);
    m_ii = MW'(x_im_i) * MW'(y_im_i);
    m_ir = MW'(x_im_i) * MW'(y_re_i);
    m_ri = MW'(x_re_i) * MW'(y_im_i);
    p_re = PW'(m_rr) + PW'(m_ii);
    p_im = PW'(m_ir) - PW'(m_ri);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
    end else if (clr_i) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
    end else if (en_i) begin
      acc_re_o <= acc_re_o + AW'(p_re);
      acc_im_o <= acc_im_o + AW'(p_im);
    end
  end
endmodule

// File: rtl/corr_drain.sv
module corr_drain #(
  parameter int NCELL = 16,
  parameter int AW    = 32,
  localparam int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic [NCELL*AW-1:0] acc_re_i,
  input  logic [NCELL*AW-1:0] acc_im_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [AW-1:0]       re_o,
  output logic [AW-1:0]       im_o
);
  always_comb begin
    re_o = '0;
    im_o = '0;
    for (int c = 0; c < NCELL; c++) begin
      if (idx_i == IDX_W'(c)) begin
        re_o = acc_re_i[c*AW +: AW];
        im_o = acc_im_i[c*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/corr_tile.sv
module corr_tile #(
  parameter int B      = 4,
  parameter int SW     = 8,
  parameter int ACC_W  = 32,
  parameter int WINDOW = 1024,
  localparam int NCELL = B * B,
  localparam int LW    = 2 * SW,
  localparam int DW    = B * LW,
  localparam int IDX_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [ACC_W-1:0] out_re_o,
  output logic [ACC_W-1:0] out_im_o,
  output logic             out_last_o
);
  logic             clr, y_load, mac_en;
  logic [IDX_W-1:0] rd_idx;
  logic [SW-1:0]    y_re_q [B];
  logic [SW-1:0]    y_im_q [B];
  logic [NCELL*ACC_W-1:0] acc_re_flat, acc_im_flat;

  corr_ctrl #(.WINDOW(WINDOW), .NCELL(NCELL)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .clr_o       (clr),
    .y_load_o    (y_load),
    .mac_en_o    (mac_en),
    .rd_idx_o    (rd_idx)
  );

  // y lanes held for the x beat that follows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < B; k++) begin
        y_re_q[k] <= '0;
        y_im_q[k] <= '0;
      end
    end else if (y_load) begin
      for (int k = 0; k < B; k++) begin
        y_re_q[k] <= in_data_i[k*LW+SW +: SW];
        y_im_q[k] <= in_data_i[k*LW +: SW];
      end
    end
  end

  for (genvar i = 0; i < B; i++) begin : g_row
    for (genvar j = 0; j < B; j++) begin : g_col
      localparam int C = i * B + j;
      corr_cell #(.SW(SW), .AW(ACC_W)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .en_i     (mac_en),
        .x_re_i   (in_data_i[i*LW+SW +: SW]),
        .x_im_i   (in_data_i[i*LW +: SW]),
        .y_re_i   (y_re_q[j]),
        .y_im_i   (y_im_q[j]),
        .acc_re_o (acc_re_flat[C*ACC_W +: ACC_W]),
        .acc_im_o (acc_im_flat[C*ACC_W +: ACC_W])
      );
    end
  end

  corr_drain #(.NCELL(NCELL), .AW(ACC_W)) u_drain (
    .acc_re_i (acc_re_flat),
    .acc_im_i (acc_im_flat),
    .idx_i    (rd_idx),
    .re_o     (out_re_o),
    .im_o     (out_im_o)
  );
endmodule

// File: rtl/corr_tile_chk.sv
module corr_tile_chk #(
  parameter int AW     = 32,
  parameter int WINDOW = 1024,
  localparam int CW = $clog2(2 * WINDOW) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [AW-1:0] out_re_o,
  input logic [AW-1:0] out_im_o,
  input logic          out_last_o
);
  logic [CW-1:0] beats_q;
  logic          beat, win_done;

  assign beat     = in_valid_i && in_ready_o;
  assign win_done = beat && (beats_q == CW'(2 * WINDOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       beats_q <= '0;
    else if (win_done) beats_q <= '0;
    else if (beat)     beats_q <= beats_q + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  assert_start_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !in_ready_o && !out_valid_o) |=> in_ready_o);

  assert_window_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done |=> (out_valid_o && !in_ready_o));

  assert_input_closed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !win_done) |=> in_ready_o);

  assert_last_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_hold_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_re_o) && $stable(out_im_o) && $stable(out_last_o)));

  assert_idle_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (!out_valid_o && !in_ready_o));
endmodule

bind corr_tile corr_tile_chk #(.AW(ACC_W), .WINDOW(WINDOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_corr_tile.sv
`timescale 1ns/1ps
module tb_corr_tile;
  localparam int B      = 4;
  localparam int SW     = 8;
  localparam int AW     = 32;
  localparam int WINDOW = 1024;
  localparam int NCELL  = B * B;
  localparam int DW     = B * 2 * SW;

  // stimulus table: seed (-1 = full scale), input gap period, output stall, stray start
  localparam int NV = 4;
  localparam int V_SEED  [NV] = '{11, 4242, 977, -1};
  localparam int V_GAP   [NV] = '{0, 5, 3, 0};
  localparam int V_STALL [NV] = '{0, 1, 0, 1};
  localparam int V_POKE  [NV] = '{0, 1, 0, 1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic out_ready_i = 1'b0;
  logic in_ready_o, out_valid_o, out_last_o;
  logic [AW-1:0] out_re_o, out_im_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  longint ref_re [NCELL];
  longint ref_im [NCELL];

  always #2 clk_i = ~clk_i;

  corr_tile #(.B(B), .SW(SW), .ACC_W(AW), .WINDOW(WINDOW)) dut (
    .clk_i, .rst_ni, .start_i, .in_valid_i, .in_ready_o, .in_data_i,
    .out_valid_o, .out_ready_i, .out_re_o, .out_im_o, .out_last_o
  );

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  function automatic int smp(int seed, int step, int lane, int part, int isx);
    int h;
    if (seed < 0) return -128;
    h = seed * 7919 + step * 131 + lane * 37 + part * 11 + isx * 53;
    h = h ^ (h >>> 5) ^ (h * 3);
    return int'($signed(h[7:0]));
  endfunction

  function automatic logic [DW-1:0] pack(int seed, int step, int isx);
    logic [DW-1:0] d;
    for (int k = 0; k < B; k++) begin
      d[k*16+8 +: 8] = 8'(smp(seed, step, k, 0, isx));
      d[k*16 +: 8]   = 8'(smp(seed, step, k, 1, isx));
    end
    return d;
  endfunction

  task automatic send_beat(logic [DW-1:0] d, bit poke);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = d;
    start_i    = poke;
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i);
  endtask

  task automatic gap(int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      start_i    = 1'b0;
      in_data_i  = {DW{g[0]}} ^ {(DW/8){8'h5a}};  // garbage, must not matter (R9)
    end
  endtask

  task automatic run_block(int seed, int gp, bit stall, bit poke);
    for (int c = 0; c < NCELL; c++) begin ref_re[c] = 0; ref_im[c] = 0; end
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 in_ready after start", longint'(in_ready_o), 1);
    for (int t = 0; t < WINDOW; t++) begin
      send_beat(pack(seed, t, 0), 1'b0);
      if (gp > 0 && (t % gp) == 1) gap(2);
      send_beat(pack(seed, t, 1), poke && (t == WINDOW / 2));  // R7 stray start
      if (gp > 0 && (t % gp) == 0) gap(1);
      for (int i = 0; i < B; i++)
        for (int j = 0; j < B; j++) begin
          longint xr, xi, yr, yi;
          xr = smp(seed, t, i, 0, 1); xi = smp(seed, t, i, 1, 1);
          yr = smp(seed, t, j, 0, 0); yi = smp(seed, t, j, 1, 0);
          ref_re[i*B+j] += xr * yr + xi * yi;  // R3
          ref_im[i*B+j] += xi * yr - xr * yi;
        end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    start_i    = 1'b0;
    chk("R4 in_ready low after window", longint'(in_ready_o), 0);
    chk("R4 out_valid after window", longint'(out_valid_o), 1);
    begin
      int k = 0;
      bit held = 1'b0;
      bit tog = 1'b0;
      logic [AW-1:0] h_re, h_im;
      while (k < NCELL) begin
        if (k > 0 || held) @(negedge clk_i);
        tog = ~tog;
        out_ready_i = stall ? tog : 1'b1;
        if (held) begin
          chk("R6 re held", longint'(out_re_o), longint'(h_re));
          chk("R6 im held", longint'(out_im_o), longint'(h_im));
          held = 1'b0;
        end
        if (out_ready_i) begin
          chk("R5 re", longint'($signed(out_re_o)), ref_re[k]);
          chk("R5 im", longint'($signed(out_im_o)), ref_im[k]);
          chk("R5 last", longint'(out_last_o), longint'(k == NCELL - 1));
          if (seed < 0) chk("R8 full scale re", longint'($signed(out_re_o)), 64'd33554432);
          k++;
          @(posedge clk_i);
        end else begin
          h_re = out_re_o;
          h_im = out_im_o;
          held = 1'b1;
          @(posedge clk_i);
        end
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk("R7 idle out_valid", longint'(out_valid_o), 0);
    chk("R7 idle in_ready", longint'(in_ready_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in_ready in reset", longint'(in_ready_o), 0);
    chk("R1 out_valid in reset", longint'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 in_ready after reset", longint'(in_ready_o), 0);
    chk("R1 out_valid after reset", longint'(out_valid_o), 0);

    for (int v = 0; v < NV; v++)
      run_block(V_SEED[v], V_GAP[v], V_STALL[v] != 0, V_POKE[v] != 0);

    // R4: beats offered while idle are ignored; next block still exact
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = {DW{1'b1}};
    repeat (4) @(negedge clk_i);
    chk("R4 in_ready idle with valid", longint'(in_ready_o), 0);
    in_valid_i = 1'b0;
    run_block(31337, 0, 1'b0, 1'b0);

    summary();
  end
endmodule